// File: doc/BRIEF.md
# Sixteen-Bit GPIO Port with Level Interrupt

This block is a general-purpose I/O port with a small word-addressed register bus. Each pin has three pieces of state: a direction bit, a data latch bit and an interrupt enable bit. A pin set as an output drives its latched value. A pin set as an input is passed through a two-flop synchronizer. Software reads that synchronized level at the data address.

Input pins that are enabled for interrupt are active-low and level-sensitive. Any such pin held low raises one registered request line. There is no status register. Software finds the requesting pins by reading the data register, where every input bit shows its synchronized level.

Two resets are supported. The power-on reset clears the direction and enable registers. The manual reset clears only the bus read pipeline, the synchronizer and the request flop, so the configuration survives it. Neither reset touches the data latch.

Top module: `gpio_lvl_port`

## Requirements
- R1: The direction register is at word address 0. Bit value 1 makes a pin an output and `pin_oe` mirrors this register. The power-on reset clears it to all inputs.
- R2: For each output bit, `pin_out` carries the data latch bit. For each input bit, `pin_out` is 0.
- R3: A read of word address 1 returns, per bit, the latch value for output bits and the two-flop synchronized pin level for input bits.
- R4: Neither reset changes the data latch. A value written before a reset reads back unchanged after it on output bits.
- R5: The interrupt enable register is at word address 2 (1 = enabled). The power-on reset clears it to 0x0000. The manual reset leaves it unchanged.
- R6: `irq` is the registered OR, over input bits whose enable bit is 1, of a low synchronized pin. Output bits never contribute. A pin falling low appears on `irq` at the third rising edge after the change.
- R7: `irq` is level-sensitive. It stays high as long as an enabled input is held low, and it falls one edge after the source is released or masked.
- R8: A read strobe with an address yields `bus_rdata` and a one-cycle `bus_rvalid` at the next edge. `bus_rvalid` is low in cycles without a strobe. Address 3 reads as 0.
- R9: The manual reset clears `irq` and `bus_rvalid` but keeps the direction register. After release, `irq` re-evaluates within three edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and sampling clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| man_rst | input | 1 | Synchronous manual reset, active high |
| bus_addr | input | 2 | Word address (0 direction, 1 data, 2 enable) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, valid one cycle after the strobe |
| bus_rvalid | output | 1 | Read data valid |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Pin drive values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Registered interrupt request, active high |

## Verification
The assertions check four things on every cycle: the power-on clearing of the direction and enable registers, that the enable register holds through a manual reset, that the data latch changes only on a data write, and the one-cycle read-valid timing. The rest needs directed bench scenarios. These are the per-bit readback mix of latch and pin, the three-edge synchronizer-plus-flop latency to `irq`, the exclusion of output bits from the interrupt, the level behaviour under hold, release and masking, and latch contents surviving both resets.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_IEN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '1;   // idle level: no spurious request
          else     stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '1;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lvl_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      data_o,
  output logic [W-1:0]      ien_o
);
  logic          wr_ok;
  logic [W-1:0]  dir_q, data_q, ien_q;

  assign wr_ok = wr_en && !por_rst && !man_rst;

  // direction: cleared by power-on reset only
  always_ff @(posedge clk) begin
    if (por_rst)                         dir_q <= '0;
    else if (wr_ok && addr == REG_DIR)   dir_q <= wdata;
  end

  // data latch: no reset at all
  always_ff @(posedge clk) begin
    if (wr_ok && addr == REG_DATA) data_q <= wdata;
  end

  // interrupt enable: cleared by power-on reset only
  always_ff @(posedge clk) begin
    if (por_rst)                         ien_q <= '0;
    else if (wr_ok && addr == REG_IEN)   ien_q <= wdata;
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;
  assign ien_o  = ien_q;

  // R1 / R5: power-on reset leaves both configuration registers cleared
  a_r1_por_clears_dir: assert property (@(posedge clk) por_rst |=> (dir_q == '0));
  a_r5_por_clears_ien: assert property (@(posedge clk) por_rst |=> (ien_q == '0));
  // R5: manual reset holds the enable register
  a_r5_man_keeps_ien: assert property (@(posedge clk) disable iff (por_rst)
    man_rst |=> (ien_q == $past(ien_q)));
  // R4: the latch moves only on an accepted data write
  a_r4_latch_only_on_write: assert property (@(posedge clk)
    !(wr_ok && addr == REG_DATA) |=> (data_q === $past(data_q)));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pin_sync_i,
  output logic         irq_o
);
  logic [W-1:0] active;
  logic         irq_q;

  assign active = ien_i & ~dir_i & ~pin_sync_i;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |active;
  end

  assign irq_o = irq_q;

  // R6: with every bit masked the request cannot rise at the next edge
  a_r6_masked_no_irq: assert property (@(posedge clk) disable iff (rst)
    (ien_i == '0) |=> !irq_o);
  // R6: with every bit set as output the request cannot rise either
  a_r6_outputs_no_irq: assert property (@(posedge clk) disable iff (rst)
    (dir_i == '1) |=> !irq_o);
endmodule

// File: rtl/gpio_lvl_port.sv
module gpio_lvl_port
  import gpio_lvl_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              man_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [W-1:0]      bus_wdata,
  input  logic              bus_rd,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_rvalid,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  logic         any_rst;
  logic [W-1:0] dir_w, data_w, ien_w, pin_s;
  logic [W-1:0] rd_mux;
  logic [W-1:0] rdata_q;
  logic         rvalid_q;

  assign any_rst = por_rst | man_rst;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (any_rst), .d_i (pin_in), .q_o (pin_s)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk (clk), .por_rst (por_rst), .man_rst (man_rst),
    .wr_en (bus_wr), .addr (bus_addr), .wdata (bus_wdata),
    .dir_o (dir_w), .data_o (data_w), .ien_o (ien_w)
  );

  gpio_irq #(.W(W)) u_irq (
    .clk (clk), .rst (any_rst), .ien_i (ien_w), .dir_i (dir_w),
    .pin_sync_i (pin_s), .irq_o (irq)
  );

  always_comb begin
    case (bus_addr)
      REG_DIR:  rd_mux = dir_w;
      REG_DATA: rd_mux = (dir_w & data_w) | (~dir_w & pin_s);
      REG_IEN:  rd_mux = ien_w;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_rd;
      if (bus_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign pin_oe     = dir_w;
  assign pin_out    = dir_w & data_w;

  // R8: valid follows the strobe by exactly one edge
  a_r8_rvalid_after_rd: assert property (@(posedge clk) disable iff (any_rst)
    bus_rd |=> bus_rvalid);
  a_r8_no_rvalid_idle: assert property (@(posedge clk) disable iff (any_rst)
    !bus_rd |=> !bus_rvalid);
  // R9: a manual reset leaves no request and no valid read behind
  a_r9_man_clears: assert property (@(posedge clk)
    man_rst |=> (!irq && !bus_rvalid));
endmodule

// File: tb/test_gpio_lvl_port.sv
`timescale 1ns/1ps
module test_gpio_lvl_port;
  logic        clk = 1'b0;
  logic        por_rst = 1'b1, man_rst = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0, pin_in = 16'hFFFF;
  logic [15:0] bus_rdata, pin_out, pin_oe;
  logic        bus_rvalid, irq;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  gpio_lvl_port i_gpio_lvl_port (
    .clk(clk), .por_rst(por_rst), .man_rst(man_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // vectors: dir, data, ien, pins -> expected read, pin_out, irq
  localparam int NV = 7;
  localparam logic [15:0] V_DIR [NV] = '{16'h0000, 16'hFF00, 16'h0000, 16'h0001, 16'h0000, 16'h0000, 16'h00FF};
  localparam logic [15:0] V_DAT [NV] = '{16'h1234, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00AA};
  localparam logic [15:0] V_IEN [NV] = '{16'h0000, 16'h0000, 16'h0001, 16'h0001, 16'h00F0, 16'h00F0, 16'hFF00};
  localparam logic [15:0] V_PIN [NV] = '{16'hA5A5, 16'hA5A5, 16'hFFFE, 16'hFFFE, 16'hFF0F, 16'hFFFF, 16'h7FFF};
  localparam logic [15:0] V_RD  [NV] = '{16'hA5A5, 16'h12A5, 16'hFFFE, 16'hFFFE, 16'hFF0F, 16'hFFFF, 16'h7FAA};
  localparam logic [15:0] V_OUT [NV] = '{16'h0000, 16'h1200, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00AA};
  localparam logic        V_IRQ [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d, output logic v);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic v;
    // power-on reset state
    repeat (3) @(posedge clk);
    @(negedge clk); por_rst = 1'b0;
    check("R1 oe after por", pin_oe, 16'h0000);
    check("R6 irq after por", {15'b0, irq}, 16'h0000);
    check("R8 rvalid idle", {15'b0, bus_rvalid}, 16'h0000);
    rd(2'd0, d, v); check("R1 dir reset", d, 16'h0000);
    check("R8 rvalid after rd", {15'b0, v}, 16'h0001);
    @(negedge clk); check("R8 rvalid drops", {15'b0, bus_rvalid}, 16'h0000);
    rd(2'd2, d, v); check("R5 ien reset", d, 16'h0000);
    rd(2'd3, d, v); check("R8 unmapped read", d, 16'h0000);

    // vector table: R1 R2 R3 R6
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_DIR[i]); wr(2'd1, V_DAT[i]); wr(2'd2, V_IEN[i]);
      pin_in = V_PIN[i];
      settle();
      rd(2'd1, d, v);
      check($sformatf("R3 readback v%0d", i), d, V_RD[i]);
      check($sformatf("R2 pin_out v%0d", i), pin_out, V_OUT[i]);
      check($sformatf("R1 pin_oe v%0d", i), pin_oe, V_DIR[i]);
      check($sformatf("R6 irq v%0d", i), {15'b0, irq}, {15'b0, V_IRQ[i]});
    end

    // latency and level behaviour: R6 R7
    wr(2'd0, 16'h0000); wr(2'd2, 16'h0001); pin_in = 16'hFFFF; settle();
    check("R6 idle irq", {15'b0, irq}, 16'h0000);
    @(negedge clk); pin_in = 16'hFFFE;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R6 irq not before third edge", {15'b0, irq}, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R6 irq on third edge", {15'b0, irq}, 16'h0001);
    repeat (5) @(posedge clk); @(negedge clk);
    check("R7 irq held while low", {15'b0, irq}, 16'h0001);
    wr(2'd2, 16'h0000);
    @(posedge clk); @(negedge clk);
    check("R7 irq drops when masked", {15'b0, irq}, 16'h0000);
    wr(2'd2, 16'h0001); settle();
    check("R7 irq back after unmask", {15'b0, irq}, 16'h0001);
    pin_in = 16'hFFFF; settle();
    check("R7 irq drops on release", {15'b0, irq}, 16'h0000);

    // manual reset: R4 R5 R9
    wr(2'd0, 16'h00FF); wr(2'd1, 16'h5A5A); wr(2'd2, 16'h0F0F);
    pin_in = 16'hF0FF; settle();
    check("R6 irq before manual reset", {15'b0, irq}, 16'h0001);
    @(negedge clk); man_rst = 1'b1;
    @(posedge clk); @(negedge clk); man_rst = 1'b0;
    check("R9 irq cleared by manual reset", {15'b0, irq}, 16'h0000);
    rd(2'd0, d, v); check("R9 dir kept", d, 16'h00FF);
    rd(2'd2, d, v); check("R5 ien kept", d, 16'h0F0F);
    rd(2'd1, d, v); check("R4 latch kept (manual)", d, 16'hF05A);
    settle();
    check("R9 irq re-evaluated", {15'b0, irq}, 16'h0001);

    // power-on reset again: R1 R4 R5
    @(negedge clk); por_rst = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk); por_rst = 1'b0;
    rd(2'd0, d, v); check("R1 dir cleared again", d, 16'h0000);
    rd(2'd2, d, v); check("R5 ien cleared by por", d, 16'h0000);
    check("R6 irq after second por", {15'b0, irq}, 16'h0000);
    wr(2'd0, 16'hFFFF);
    rd(2'd1, d, v); check("R4 latch kept (por)", d, 16'h5A5A);
    check("R2 pin_out from kept latch", pin_out, 16'h5A5A);

    finish_run();
  end
endmodule